// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Host-Command Vector

This block sits beside a DSP core's instruction sequencer. It gathers up to 32 interrupt request lines into a set of pending bits. Each source carries a two-bit priority level, and one code of that level marks the source as disabled. When the sequencer reports that an instruction has finished, the controller picks one pending source. That source must be enabled and at or above the current interrupt mask from the status register. The controller then issues a one-cycle take strobe with the program-counter vector of that source.

Source 22 is reserved for host commands and has no fixed vector. A host writes a command register that holds a command flag and a five-bit vector number. The flag is mirrored as a host-status pending bit. When the host-command enable is also set, the flag raises source 22. Its vector is the vector number doubled, and taking it clears the flag, so the host can see that the command was accepted.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `take_o` is 0. Reset clears every pending bit, the command register and `hcp_o`.
- R2: A 1 on `req_i[n]` at a clock edge sets pending bit n, which shows on `pending_o[n]` from that edge on. The bit stays set until source n is taken.
- R3: Arbitration happens only at an edge where `insn_done_i` is 1. `take_o`, `take_src_o` and `vector_o` update at that edge, and `take_o` is high for exactly one cycle per strobe.
- R4: Of the accepted pending sources, the one with the numerically highest level wins.
- R5: When accepted sources share the highest level, the lowest source index wins.
- R6: A take clears only the winner's pending bit. Sources that lost arbitration stay pending.
- R7: Source n's level is `prio_i[2n+1:2n]`. A source is accepted only if its level is greater than or equal to `imask_i`.
- R8: Level code 3 means disabled. Such a source is never taken at any mask value, and its pending bit stays set.
- R9: A source other than 22 is taken with `vector_o` = 2 × its index, for example 0x0026 for source 19. `take_src_o` gives the index.
- R10: A write through `cvr_wr_i` loads the command register `cvr_o`. Bit 7 is the command flag, bits 4:0 are the vector number, and bits 6:5 are held as written with no effect. `hcp_o` equals the flag. `pending_o[22]` is flag AND `hc_en_i`.
- R11: Taking source 22 gives `vector_o` = (`cvr_o[4:0]` << 1) and `take_src_o` = 22. The same edge clears the flag and `hcp_o` and leaves bits 6:0 unchanged.
- R12: `req_i[22]` has no effect. It sets no pending bit and causes no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 32 | Interrupt request lines, one per source |
| prio_i | input | 64 | Two-bit level per source; code 3 disables |
| imask_i | input | 2 | Current interrupt mask level |
| insn_done_i | input | 1 | Instruction-complete strobe that triggers arbitration |
| cvr_wr_i | input | 1 | Host write strobe for the command register |
| cvr_wdata_i | input | 8 | Host write data for the command register |
| hc_en_i | input | 1 | Host-command interrupt enable |
| pending_o | output | 32 | Effective pending set; bit 22 is the host request |
| take_o | output | 1 | One-cycle strobe: an interrupt is taken |
| take_src_o | output | 5 | Index of the taken source |
| vector_o | output | 16 | Vector address to load into the program counter |
| cvr_o | output | 8 | Command register contents |
| hcp_o | output | 1 | Host-status command-pending bit |

## Verification
A request pulse becomes visible on `pending_o` after one edge. Changing `hc_en_i` reaches `pending_o[22]` with no edge at all. A take appears on the edge that samples `insn_done_i` and lasts one cycle. The winner's pending bit and the host command flag clear on that same edge. The bench drives every input on the falling edge and reads results on the next falling edge, which is half a period after the edge that made them. Quiet stretches and the cycle after each strobe are also sampled, to show that nothing is taken early or twice.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int IC_NSRC  = 32;
    localparam int IC_LVL_W = 2;
    localparam int IC_VEC_W = 16;
    localparam int IC_IDX_W = $clog2(IC_NSRC);
    localparam int IC_HC_VN_W = 5;

    typedef logic [IC_VEC_W-1:0] ic_vec_t;
    typedef logic [IC_LVL_W-1:0] ic_lvl_t;
    typedef logic [IC_IDX_W-1:0] ic_idx_t;

    localparam ic_lvl_t LVL_DISABLED = '1;

    typedef struct packed {
        logic    valid;
        ic_idx_t idx;
        ic_lvl_t lvl;
    } ic_grant_t;

    typedef struct packed {
        logic                  flag;
        logic [1:0]            spare;
        logic [IC_HC_VN_W-1:0] vnum;
    } ic_cvr_t;

    function automatic ic_vec_t fixed_vector(input ic_idx_t idx);
        return ic_vec_t'({idx, 1'b0});
    endfunction

    function automatic ic_vec_t host_vector(input logic [IC_HC_VN_W-1:0] vn);
        return ic_vec_t'({vn, 1'b0});
    endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = IC_NSRC,
    parameter int HC_IDX  = 22
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               hc_req_i,
    output logic [NUM_SRC-1:0] pend_o
);
    localparam logic [NUM_SRC-1:0] HC_BIT = {{(NUM_SRC-1){1'b0}}, 1'b1} << HC_IDX;

    logic [NUM_SRC-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= ((pend_q & ~clr_i) | req_i) & ~HC_BIT;
    end

    always_comb begin
        pend_o = pend_q;
        pend_o[HC_IDX] = hc_req_i;
    end

    // R6
    clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_i));

    // R2
    no_spurious_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((($past(pend_q) & ~pend_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = IC_NSRC
) (
    input  logic [NUM_SRC-1:0]          pend_i,
    input  logic [NUM_SRC*IC_LVL_W-1:0] prio_i,
    input  ic_lvl_t                     imask_i,
    output ic_grant_t                   grant_o
);
    always_comb begin
        grant_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i]
                && prio_i[i*IC_LVL_W +: IC_LVL_W] != LVL_DISABLED
                && prio_i[i*IC_LVL_W +: IC_LVL_W] >= imask_i
                && (!grant_o.valid || prio_i[i*IC_LVL_W +: IC_LVL_W] > grant_o.lvl)) begin
                grant_o.valid = 1'b1;
                grant_o.idx   = i[IC_IDX_W-1:0];
                grant_o.lvl   = prio_i[i*IC_LVL_W +: IC_LVL_W];
            end
        end
    end
endmodule

// File: rtl/irq_host_cmd.sv
module irq_host_cmd
    import irq_prio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_i,
    input  ic_cvr_t wdata_i,
    input  logic    hc_en_i,
    input  logic    take_i,
    output ic_cvr_t cvr_o,
    output logic    hc_req_o
);
    ic_cvr_t cvr_q;

    always_ff @(posedge clk) begin
        if (rst)         cvr_q <= '0;
        else if (wr_i)   cvr_q <= wdata_i;
        else if (take_i) cvr_q.flag <= 1'b0;
    end

    assign cvr_o    = cvr_q;
    assign hc_req_o = cvr_q.flag & hc_en_i;

    // R11
    hc_flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(take_i) && !$past(wr_i) && !$past(rst)) |-> !cvr_q.flag);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = IC_NSRC,
    parameter int HC_IDX  = 22
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          req_i,
    input  logic [NUM_SRC*IC_LVL_W-1:0] prio_i,
    input  logic [IC_LVL_W-1:0]         imask_i,
    input  logic                        insn_done_i,
    input  logic                        cvr_wr_i,
    input  logic [7:0]                  cvr_wdata_i,
    input  logic                        hc_en_i,
    output logic [NUM_SRC-1:0]          pending_o,
    output logic                        take_o,
    output logic [IC_IDX_W-1:0]         take_src_o,
    output logic [IC_VEC_W-1:0]         vector_o,
    output logic [7:0]                  cvr_o,
    output logic                        hcp_o
);
    localparam ic_idx_t HC_SEL = HC_IDX[IC_IDX_W-1:0];

    ic_grant_t          grant;
    ic_cvr_t            cvr;
    logic               hc_req;
    logic               fire;
    logic               take_hc;
    logic [NUM_SRC-1:0] clr;

    assign fire    = insn_done_i & grant.valid;
    assign take_hc = fire & (grant.idx == HC_SEL);

    always_comb begin
        clr = '0;
        if (fire && !take_hc) clr[grant.idx] = 1'b1;
    end

    irq_pending #(.NUM_SRC(NUM_SRC), .HC_IDX(HC_IDX)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .clr_i    (clr),
        .hc_req_i (hc_req),
        .pend_o   (pending_o)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend_i  (pending_o),
        .prio_i  (prio_i),
        .imask_i (imask_i),
        .grant_o (grant)
    );

    irq_host_cmd u_host (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (cvr_wr_i),
        .wdata_i  (ic_cvr_t'(cvr_wdata_i)),
        .hc_en_i  (hc_en_i),
        .take_i   (take_hc),
        .cvr_o    (cvr),
        .hc_req_o (hc_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            take_src_o <= '0;
            vector_o   <= '0;
        end else begin
            take_o <= fire;
            if (fire) begin
                take_src_o <= grant.idx;
                vector_o   <= take_hc ? host_vector(cvr.vnum) : fixed_vector(grant.idx);
            end
        end
    end

    assign cvr_o = cvr;
    assign hcp_o = cvr.flag;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !take_o);

    // R3
    take_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(insn_done_i));

    // R7
    mask_respected_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ($past(grant.lvl) >= $past(imask_i) && $past(grant.lvl) != LVL_DISABLED));

    // R9
    vector_even_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (vector_o[0] == 1'b0));
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req_i = '0;
    logic [63:0] prio_i = '1;
    logic [1:0]  imask_i = '0;
    logic        insn_done_i = 1'b0;
    logic        cvr_wr_i = 1'b0;
    logic [7:0]  cvr_wdata_i = '0;
    logic        hc_en_i = 1'b0;
    logic [31:0] pending_o;
    logic        take_o;
    logic [4:0]  take_src_o;
    logic [15:0] vector_o;
    logic [7:0]  cvr_o;
    logic        hcp_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst(rst), .req_i(req_i), .prio_i(prio_i), .imask_i(imask_i),
        .insn_done_i(insn_done_i), .cvr_wr_i(cvr_wr_i), .cvr_wdata_i(cvr_wdata_i),
        .hc_en_i(hc_en_i), .pending_o(pending_o), .take_o(take_o),
        .take_src_o(take_src_o), .vector_o(vector_o), .cvr_o(cvr_o), .hcp_o(hcp_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_lvl(input int src, input logic [1:0] lvl);
        prio_i[src*2 +: 2] = lvl;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_i = '0; prio_i = '1; imask_i = '0; insn_done_i = 1'b0;
        cvr_wr_i = 1'b0; cvr_wdata_i = '0; hc_en_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_req(input logic [31:0] bits);
        @(negedge clk); req_i = bits;
        @(negedge clk); req_i = '0;
    endtask

    // Raise insn_done for one edge; outputs are left valid for sampling.
    task automatic pulse_done();
        @(negedge clk); insn_done_i = 1'b1;
        @(negedge clk); insn_done_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; req_i = 32'h0000_00ff; insn_done_i = 1'b1; prio_i = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 take in reset", take_o, 0);
        chk("R1 pending in reset", pending_o, 0);
        chk("R1 cvr in reset", cvr_o, 0);
        chk("R1 hcp in reset", hcp_o, 0);
        do_reset();
    endtask

    task automatic t_latch();
        do_reset();
        set_lvl(5, 2'd1);
        pulse_req(32'h1 << 5);
        chk("R2 pending set", pending_o, 32'h1 << 5);
        repeat (3) @(negedge clk);
        chk("R2 pending held", pending_o, 32'h1 << 5);
        chk("R3 no take without done", take_o, 0);
        pulse_done();
        chk("R3 take strobe", take_o, 1);
        chk("R9 src 5", take_src_o, 5);
        chk("R9 vector src 5", vector_o, 16'h000A);
        @(negedge clk);
        chk("R3 strobe one cycle", take_o, 0);
        chk("R6 winner cleared", pending_o, 0);
    endtask

    task automatic t_prio();
        do_reset();
        set_lvl(3, 2'd1); set_lvl(7, 2'd2);
        pulse_req((32'h1 << 3) | (32'h1 << 7));
        pulse_done();
        chk("R4 higher level wins", take_src_o, 7);
        chk("R9 vector src 7", vector_o, 16'h000E);
        chk("R6 loser stays pending", pending_o, 32'h1 << 3);
        pulse_done();
        chk("R6 loser taken later", take_src_o, 3);
        chk("R9 vector src 3", vector_o, 16'h0006);
    endtask

    task automatic t_tie();
        do_reset();
        set_lvl(4, 2'd1); set_lvl(9, 2'd1);
        pulse_req((32'h1 << 4) | (32'h1 << 9));
        pulse_done();
        chk("R5 tie lower index", take_src_o, 4);
        chk("R6 tie loser pending", pending_o, 32'h1 << 9);
    endtask

    task automatic t_mask();
        do_reset();
        set_lvl(12, 2'd1); imask_i = 2'd2;
        pulse_req(32'h1 << 12);
        pulse_done();
        chk("R7 masked no take", take_o, 0);
        chk("R7 masked stays pending", pending_o, 32'h1 << 12);
        imask_i = 2'd1;
        pulse_done();
        chk("R7 level equal mask taken", take_o, 1);
        chk("R7 src 12", take_src_o, 12);
    endtask

    task automatic t_disabled();
        do_reset();
        set_lvl(15, 2'd3); set_lvl(19, 2'd0);
        pulse_req((32'h1 << 15) | (32'h1 << 19));
        pulse_done();
        chk("R9 src 19", take_src_o, 19);
        chk("R9 vector 0x26", vector_o, 16'h0026);
        pulse_done();
        chk("R8 disabled not taken", take_o, 0);
        chk("R8 disabled stays pending", pending_o, 32'h1 << 15);
    endtask

    task automatic t_host();
        do_reset();
        set_lvl(22, 2'd0);
        @(negedge clk); cvr_wr_i = 1'b1; cvr_wdata_i = 8'hE5;
        @(negedge clk); cvr_wr_i = 1'b0;
        chk("R10 cvr written", cvr_o, 8'hE5);
        chk("R10 hcp follows flag", hcp_o, 1);
        chk("R10 no request without enable", pending_o[22], 0);
        pulse_done();
        chk("R10 no take without enable", take_o, 0);
        @(negedge clk); hc_en_i = 1'b1;
        @(negedge clk);
        chk("R10 request with enable", pending_o[22], 1);
        pulse_done();
        chk("R11 host take", take_o, 1);
        chk("R11 host src", take_src_o, 22);
        chk("R11 host vector", vector_o, 16'h000A);
        chk("R11 flag cleared", cvr_o, 8'h65);
        chk("R11 hcp cleared", hcp_o, 0);
        @(negedge clk);
        chk("R11 no second take", take_o, 0);
    endtask

    task automatic t_req22();
        do_reset();
        set_lvl(22, 2'd2); hc_en_i = 1'b1;
        pulse_req(32'h1 << 22);
        chk("R12 req 22 ignored", pending_o, 0);
        pulse_done();
        chk("R12 no take from req 22", take_o, 0);
    endtask

    task automatic t_reset_mid();
        do_reset();
        set_lvl(1, 2'd1);
        pulse_req(32'h0000_0F02);
        chk("R2 multi pending", pending_o, 32'h0000_0F02);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset clears pending", pending_o, 0);
        pulse_done();
        chk("R1 no take after reset", take_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latch();
        t_prio();
        t_tie();
        t_mask();
        t_disabled();
        t_host();
        t_req22();
        t_reset_mid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule